// File: doc/BRIEF.md
# Four-Channel Wiper Register Bank Controller

This block is the control core of a four-channel digital potentiometer. Each channel owns a 6-bit wiper register that drives a tap-select output (one of 64 positions) and four 6-bit retained data registers. A parallel command port stands in for an already-decoded serial bus. Through it a host can read or write wipers and data registers, copy a wiper into one of its channel's data registers and back, and nudge a wiper one tap at a time.

Commands carry a 4-bit device address that must match the strap inputs. Writes that reach a data register are blocked while the active-low protect input is low. An accepted retained write opens a programming window of `WR_CYCLES` clocks. Inside that window every command is refused and `busy` is high. After reset, and on each `recall` pulse, data register 0 of every channel is copied into its wiper. The data registers are plain flops, so they keep their contents across a recall.

The sequencer has three states:
- `ST_RECALL`: the copy cycle. It always moves to `ST_IDLE` on the next edge.
- `ST_IDLE`: accepts commands. It moves to `ST_RECALL` when `recall` is seen, and to `ST_PROG` when a retained write is accepted.
- `ST_PROG`: the programming window. It counts down and returns to `ST_IDLE` once the count reaches zero.

Reset enters `ST_RECALL`.

Top module: `potbank_ctrl`

## Requirements
- R1: Reset clears all registers and passes through one recall cycle. A `recall` pulse sampled in idle at edge k blocks commands at edge k+1, loads data register 0 of each channel into its wiper at edge k+1, and leaves all data registers unchanged.
- R2: An accepted wiper write (op 1) sets that channel's `tap_sel` field (bits c*6+5..c*6) to `cmd_data` after the sampling edge, and `ack` pulses for one cycle.
- R3: An accepted read of a wiper (op 0) or of a data register (op 2, slot `cmd_slot`) places the value on `rd_data` with `ack` in the cycle after the sampling edge.
- R4: An accepted retained write (op 3 writes `cmd_data`, op 4 saves the wiper) raises `busy` in the cycle after acceptance. `busy` stays high for exactly `WR_CYCLES` cycles.
- R5: While `busy` is high, every command is answered with `nack`, and no wiper or data register changes.
- R6: When `wp_n` is low, ops 3 and 4 are refused with `nack` and leave the data registers unchanged. Wiper writes (op 1) and restores are still accepted.
- R7: A command whose `cmd_addr` differs from `strap` is refused with `nack` and changes nothing.
- R8: Op 4 copies the wiper of `cmd_chan` into data register `cmd_slot`. Op 5 copies that data register into the wiper.
- R9: Op 6 raises a wiper by one tap and holds it at 63. Op 7 lowers it by one tap and holds it at 0.
- R10: Every command gets exactly one of `ack` or `nack`, one cycle after its sampling edge, and the two are never high together. A command sampled in the same cycle as a `recall` pulse is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| recall | input | 1 | Pulse requesting copy of data register 0 into every wiper |
| wp_n | input | 1 | Active-low protection of the data registers |
| strap | input | 4 | Device address straps |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_addr | input | 4 | Device address carried by the command |
| cmd_op | input | 3 | Operation code (0 to 7, see requirements) |
| cmd_chan | input | 2 | Channel selector |
| cmd_slot | input | 2 | Data register index within the channel |
| cmd_data | input | 6 | Write data |
| ack | output | 1 | Command accepted (one-cycle pulse) |
| nack | output | 1 | Command refused (one-cycle pulse) |
| rd_data | output | 6 | Read result, valid with `ack` on a read |
| busy | output | 1 | Programming window active |
| tap_sel | output | 24 | Four 6-bit tap positions, channel c at bits c*6 and up |

## Verification
A command driven before edge k has its result at edge k itself: `ack` or `nack`, `rd_data` and the new `tap_sel` all appear just after that edge. The bench reads them at the following falling edge. A retained write accepted at edge k keeps `busy` high after edges k through k+WR_CYCLES-1 and refuses commands at edges k+1 through k+WR_CYCLES. A recall seen at edge k loads the wipers at edge k+1. The reference model in the bench tracks these windows by counting edges, and the scoreboard matches responses in order.

// File: rtl/potbank_pkg.sv
package potbank_pkg;

    typedef enum logic [2:0] {
        OP_RD_WIPER = 3'd0,
        OP_WR_WIPER = 3'd1,
        OP_RD_DATA  = 3'd2,
        OP_WR_DATA  = 3'd3,
        OP_SAVE     = 3'd4,
        OP_RESTORE  = 3'd5,
        OP_STEP_UP  = 3'd6,
        OP_STEP_DN  = 3'd7
    } pot_op_e;

    typedef enum logic [1:0] {
        ST_RECALL = 2'd0,
        ST_IDLE   = 2'd1,
        ST_PROG   = 2'd2
    } seq_state_e;

    function automatic logic is_retained_write(input pot_op_e op);
        return (op == OP_WR_DATA) || (op == OP_SAVE);
    endfunction

endpackage

// File: rtl/potbank_seq.sv
module potbank_seq
    import potbank_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int WR_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              recall_req,
    input  logic              wp_n,
    input  logic [ADDR_W-1:0] strap,
    input  logic              cmd_valid,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [2:0]        cmd_op,
    output logic              accept,
    output logic              recall_now,
    output logic              busy,
    output logic              ack,
    output logic              nack
);

    localparam int CNT_W = $clog2(WR_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WR_CYCLES - 1);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             ack_q, nack_q;
    logic             nv_write;
    logic             refuse;

    // Decide acceptance and next state
    always_comb begin
        nv_write = is_retained_write(pot_op_e'(cmd_op));
        accept   = 1'b0;
        state_d  = state_q;
        cnt_d    = cnt_q;
        unique case (state_q)
            ST_RECALL: begin
                state_d = ST_IDLE;
            end
            ST_IDLE: begin
                accept = cmd_valid && !recall_req && (cmd_addr == strap)
                         && !(nv_write && !wp_n);
                if (recall_req) begin
                    state_d = ST_RECALL;
                end else if (accept && nv_write) begin
                    state_d = ST_PROG;
                    cnt_d   = CNT_LOAD;
                end
            end
            ST_PROG: begin
                if (cnt_q == '0) begin
                    state_d = ST_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        refuse = cmd_valid && !accept;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RECALL;
            cnt_q   <= '0;
            ack_q   <= 1'b0;
            nack_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            ack_q   <= accept;
            nack_q  <= refuse;
        end
    end

    // Outputs
    always_comb begin
        busy       = (state_q == ST_PROG);
        recall_now = (state_q == ST_RECALL);
        ack        = ack_q;
        nack       = nack_q;
    end

endmodule

// File: rtl/potbank_wiper.sv
module potbank_wiper #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  logic         step_up,
    input  logic         step_dn,
    output logic [W-1:0] pos
);

    localparam logic [W-1:0] POS_MAX = '1;

    logic [W-1:0] pos_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (load_en) begin
            pos_q <= load_val;
        end else if (step_up && (pos_q != POS_MAX)) begin
            pos_q <= pos_q + 1'b1;
        end else if (step_dn && (pos_q != '0)) begin
            pos_q <= pos_q - 1'b1;
        end
    end

    assign pos = pos_q;

endmodule

// File: rtl/potbank_store.sv
module potbank_store #(
    parameter int CH    = 4,
    parameter int SLOTS = 4,
    parameter int W     = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(CH)-1:0]    wr_ch,
    input  logic [$clog2(SLOTS)-1:0] wr_slot,
    input  logic [W-1:0]             wdata,
    input  logic [$clog2(CH)-1:0]    rd_ch,
    input  logic [$clog2(SLOTS)-1:0] rd_slot,
    output logic [W-1:0]             rd_val,
    output logic [CH*W-1:0]          slot0_flat
);

    logic [W-1:0] mem [CH][SLOTS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < CH; c++) begin
                for (int s = 0; s < SLOTS; s++) begin
                    mem[c][s] <= '0;
                end
            end
        end else if (we) begin
            mem[wr_ch][wr_slot] <= wdata;
        end
    end

    assign rd_val = mem[rd_ch][rd_slot];

    for (genvar c = 0; c < CH; c++) begin : g_slot0
        assign slot0_flat[c*W +: W] = mem[c][0];
    end

endmodule

// File: rtl/potbank_ctrl.sv
module potbank_ctrl
    import potbank_pkg::*;
#(
    parameter int CH        = 4,
    parameter int SLOTS     = 4,
    parameter int W         = 6,
    parameter int ADDR_W    = 4,
    parameter int WR_CYCLES = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     recall,
    input  logic                     wp_n,
    input  logic [ADDR_W-1:0]        strap,
    input  logic                     cmd_valid,
    input  logic [ADDR_W-1:0]        cmd_addr,
    input  logic [2:0]               cmd_op,
    input  logic [$clog2(CH)-1:0]    cmd_chan,
    input  logic [$clog2(SLOTS)-1:0] cmd_slot,
    input  logic [W-1:0]             cmd_data,
    output logic                     ack,
    output logic                     nack,
    output logic [W-1:0]             rd_data,
    output logic                     busy,
    output logic [CH*W-1:0]          tap_sel
);

    localparam int CH_W = $clog2(CH);

    pot_op_e      op;
    logic         accept;
    logic         recall_now;
    logic [W-1:0] wiper_pos [CH];
    logic [W-1:0] store_rd;
    logic [CH*W-1:0] slot0_flat;
    logic         store_we;
    logic [W-1:0] store_wdata;
    logic [W-1:0] rd_q;

    assign op = pot_op_e'(cmd_op);

    potbank_seq #(
        .ADDR_W    (ADDR_W),
        .WR_CYCLES (WR_CYCLES)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .recall_req (recall),
        .wp_n       (wp_n),
        .strap      (strap),
        .cmd_valid  (cmd_valid),
        .cmd_addr   (cmd_addr),
        .cmd_op     (cmd_op),
        .accept     (accept),
        .recall_now (recall_now),
        .busy       (busy),
        .ack        (ack),
        .nack       (nack)
    );

    assign store_we    = accept && is_retained_write(op);
    assign store_wdata = (op == OP_SAVE) ? wiper_pos[cmd_chan] : cmd_data;

    potbank_store #(
        .CH    (CH),
        .SLOTS (SLOTS),
        .W     (W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (store_we),
        .wr_ch      (cmd_chan),
        .wr_slot    (cmd_slot),
        .wdata      (store_wdata),
        .rd_ch      (cmd_chan),
        .rd_slot    (cmd_slot),
        .rd_val     (store_rd),
        .slot0_flat (slot0_flat)
    );

    for (genvar c = 0; c < CH; c++) begin : g_chan
        logic         sel;
        logic         load_en;
        logic [W-1:0] load_val;

        assign sel      = accept && (cmd_chan == CH_W'(c));
        assign load_en  = recall_now
                          || (sel && ((op == OP_WR_WIPER) || (op == OP_RESTORE)));
        assign load_val = recall_now          ? slot0_flat[c*W +: W] :
                          (op == OP_WR_WIPER) ? cmd_data : store_rd;

        potbank_wiper #(
            .W (W)
        ) u_wiper (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_en  (load_en),
            .load_val (load_val),
            .step_up  (sel && (op == OP_STEP_UP)),
            .step_dn  (sel && (op == OP_STEP_DN)),
            .pos      (wiper_pos[c])
        );

        assign tap_sel[c*W +: W] = wiper_pos[c];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (accept && (op == OP_RD_WIPER)) begin
            rd_q <= wiper_pos[cmd_chan];
        end else if (accept && (op == OP_RD_DATA)) begin
            rd_q <= store_rd;
        end
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/potbank_ctrl_chk.sv
module potbank_ctrl_chk #(
    parameter int CH     = 4,
    parameter int W      = 6,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wp_n,
    input logic [ADDR_W-1:0] strap,
    input logic              cmd_valid,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [2:0]        cmd_op,
    input logic              ack,
    input logic              nack,
    input logic              busy,
    input logic [CH*W-1:0]   tap_sel
);

    p_ack_nack_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack && nack));

    p_nack_has_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        nack |-> $past(cmd_valid));

    p_busy_refuses_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |=> (nack && !ack));

    p_busy_freezes_taps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(tap_sel));

    p_protect_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !wp_n && ((cmd_op == 3'd3) || (cmd_op == 3'd4))) |=> !ack);

    p_addr_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_addr != strap)) |=> (nack && !ack));

    p_busy_after_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ack);

endmodule

bind potbank_ctrl potbank_ctrl_chk #(
    .CH     (CH),
    .W      (W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wp_n      (wp_n),
    .strap     (strap),
    .cmd_valid (cmd_valid),
    .cmd_addr  (cmd_addr),
    .cmd_op    (cmd_op),
    .ack       (ack),
    .nack      (nack),
    .busy      (busy),
    .tap_sel   (tap_sel)
);

// File: tb/potbank_ctrl_bench.sv
`timescale 1ns/1ps
module potbank_ctrl_bench;

    localparam int WR = 8;
    localparam logic [3:0] STRAP = 4'hA;

    typedef struct {
        bit         want_ack;
        bit         has_data;
        logic [5:0] data;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        recall = 1'b0;
    logic        wp_n = 1'b1;
    logic [3:0]  strap = STRAP;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_addr = '0;
    logic [2:0]  cmd_op = '0;
    logic [1:0]  cmd_chan = '0;
    logic [1:0]  cmd_slot = '0;
    logic [5:0]  cmd_data = '0;
    logic        ack, nack, busy;
    logic [5:0]  rd_data;
    logic [23:0] tap_sel;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int block_end = 0;
    logic [5:0] wip [4];
    logic [5:0] dr  [4][4];
    exp_t q [$];
    exp_t mon_e;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    potbank_ctrl #(.WR_CYCLES(WR)) u_potbank_ctrl (
        .clk(clk), .rst_n(rst_n), .recall(recall), .wp_n(wp_n), .strap(strap),
        .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_op(cmd_op),
        .cmd_chan(cmd_chan), .cmd_slot(cmd_slot), .cmd_data(cmd_data),
        .ack(ack), .nack(nack), .rd_data(rd_data), .busy(busy), .tap_sel(tap_sel)
    );

    // Monitor: pops expected responses in order
    always @(negedge clk) begin
        if (rst_n && (ack || nack)) begin
            checks++;
            if (q.size() == 0) begin
                fails++;
                $display("FAIL R10 stray response: ack=%0b nack=%0b, expected none", ack, nack);
            end else begin
                mon_e = q.pop_front();
                if (ack !== mon_e.want_ack || nack !== !mon_e.want_ack) begin
                    fails++;
                    $display("FAIL %s: ack=%0b nack=%0b, expected ack=%0b",
                             mon_e.tag, ack, nack, mon_e.want_ack);
                end else if (mon_e.has_data && rd_data !== mon_e.data) begin
                    fails++;
                    $display("FAIL %s: rd_data=%0d, expected %0d", mon_e.tag, rd_data, mon_e.data);
                end
            end
        end
    end

    task automatic issue(input logic [2:0] op, input int ch, input int sl,
                         input logic [5:0] d, input logic [3:0] a,
                         input bit with_recall, input string tag);
        int   k;
        bit   acc;
        exp_t e;
        k   = cyc + 1;
        acc = (k > block_end) && (a == STRAP) && !with_recall
              && !(((op == 3'd3) || (op == 3'd4)) && !wp_n);
        e.want_ack = acc; e.has_data = 1'b0; e.data = '0; e.tag = tag;
        if (acc) begin
            case (op)
                3'd0: begin e.has_data = 1'b1; e.data = wip[ch]; end
                3'd1: wip[ch] = d;
                3'd2: begin e.has_data = 1'b1; e.data = dr[ch][sl]; end
                3'd3: begin dr[ch][sl] = d; block_end = k + WR; end
                3'd4: begin dr[ch][sl] = wip[ch]; block_end = k + WR; end
                3'd5: wip[ch] = dr[ch][sl];
                3'd6: if (wip[ch] != 6'd63) wip[ch] = wip[ch] + 6'd1;
                default: if (wip[ch] != 6'd0) wip[ch] = wip[ch] - 6'd1;
            endcase
        end
        if (with_recall) begin
            for (int c = 0; c < 4; c++) wip[c] = dr[c][0];
            block_end = k + 1;
        end
        q.push_back(e);
        cmd_valid = 1'b1; cmd_op = op; cmd_chan = ch[1:0]; cmd_slot = sl[1:0];
        cmd_data = d; cmd_addr = a; recall = with_recall;
        @(negedge clk);
        cmd_valid = 1'b0; recall = 1'b0;
    endtask

    task automatic do_recall();
        for (int c = 0; c < 4; c++) wip[c] = dr[c][0];
        block_end = cyc + 2;
        recall = 1'b1;
        @(negedge clk);
        recall = 1'b0;
        @(negedge clk);
    endtask

    task automatic chk_taps(input string tag);
        for (int c = 0; c < 4; c++) begin
            checks++;
            if (tap_sel[c*6 +: 6] !== wip[c]) begin
                fails++;
                $display("FAIL %s: tap%0d=%0d, expected %0d", tag, c, tap_sel[c*6 +: 6], wip[c]);
            end
        end
    endtask

    task automatic chk_bit(input logic act, input logic expv, input string tag);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: got %0b, expected %0b", tag, act, expv);
        end
    endtask

    task automatic wait_idle();
        repeat (WR + 1) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        finish_run();
    end

    initial begin
        for (int c = 0; c < 4; c++) begin
            wip[c] = '0;
            for (int s = 0; s < 4; s++) dr[c][s] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state, R10 quiet outputs
        chk_taps("R1 reset taps");
        chk_bit(busy, 1'b0, "R1 reset busy");
        chk_bit(ack, 1'b0, "R10 reset ack");
        chk_bit(nack, 1'b0, "R10 reset nack");

        // R2 wiper writes, R3 wiper read
        issue(3'd1, 0, 0, 6'd10, STRAP, 0, "R2 write wiper0");
        issue(3'd1, 3, 0, 6'd63, STRAP, 0, "R2 write wiper3");
        chk_taps("R2 taps after writes");
        issue(3'd0, 0, 0, 6'd0, STRAP, 0, "R3 read wiper0");

        // R4 retained write and busy window, R5 refusal inside it
        issue(3'd3, 1, 2, 6'd33, STRAP, 0, "R4 write data1.2");
        chk_bit(busy, 1'b1, "R4 busy first cycle");
        issue(3'd1, 2, 0, 6'd5, STRAP, 0, "R5 wiper write while busy");
        chk_taps("R5 taps unchanged while busy");
        repeat (WR - 2) @(negedge clk);
        chk_bit(busy, 1'b1, "R4 busy last cycle");
        @(negedge clk);
        chk_bit(busy, 1'b0, "R4 busy ends");
        issue(3'd2, 1, 2, 6'd0, STRAP, 0, "R3 read data1.2");

        // R7 address mismatch
        issue(3'd1, 0, 0, 6'd55, 4'h3, 0, "R7 wrong address");
        chk_taps("R7 taps unchanged");

        // R6 write protection
        wp_n = 1'b0;
        issue(3'd3, 2, 1, 6'd9, STRAP, 0, "R6 protected data write");
        issue(3'd4, 0, 3, 6'd0, STRAP, 0, "R6 protected save");
        issue(3'd1, 2, 0, 6'd21, STRAP, 0, "R6 wiper write allowed");
        issue(3'd2, 2, 1, 6'd0, STRAP, 0, "R6 readback data2.1");
        issue(3'd2, 0, 3, 6'd0, STRAP, 0, "R6 readback data0.3");
        chk_taps("R6 taps");
        wp_n = 1'b1;

        // R8 save and restore
        issue(3'd4, 0, 1, 6'd0, STRAP, 0, "R8 save wiper0 to slot1");
        wait_idle();
        issue(3'd2, 0, 1, 6'd0, STRAP, 0, "R8 read saved value");
        issue(3'd5, 1, 2, 6'd0, STRAP, 0, "R8 restore slot2 to wiper1");
        chk_taps("R8 taps after restore");

        // R9 steps with saturation
        issue(3'd6, 3, 0, 6'd0, STRAP, 0, "R9 up at 63");
        issue(3'd1, 2, 0, 6'd0, STRAP, 0, "R9 set wiper2 to 0");
        issue(3'd7, 2, 0, 6'd0, STRAP, 0, "R9 down at 0");
        issue(3'd6, 0, 0, 6'd0, STRAP, 0, "R9 up");
        chk_taps("R9 taps after up");
        issue(3'd7, 0, 0, 6'd0, STRAP, 0, "R9 down");
        issue(3'd7, 0, 0, 6'd0, STRAP, 0, "R9 down again");
        chk_taps("R9 taps after steps");
        issue(3'd0, 3, 0, 6'd0, STRAP, 0, "R9 read saturated wiper3");

        // R1 recall
        issue(3'd3, 0, 0, 6'd7, STRAP, 0, "R1 seed data0.0");
        wait_idle();
        issue(3'd3, 3, 0, 6'd40, STRAP, 0, "R1 seed data3.0");
        wait_idle();
        do_recall();
        chk_taps("R1 taps after recall");
        issue(3'd2, 1, 2, 6'd0, STRAP, 0, "R1 data kept across recall");

        // R10 command colliding with recall
        issue(3'd1, 1, 0, 6'd12, STRAP, 1, "R10 command with recall");
        @(negedge clk);
        chk_taps("R10 taps after colliding recall");
        issue(3'd1, 1, 0, 6'd12, STRAP, 0, "R10 command after recall");
        chk_taps("R10 final taps");

        repeat (3) @(negedge clk);
        checks++;
        if (q.size() != 0) begin
            fails++;
            $display("FAIL R10 missing responses: %0d pending, expected 0", q.size());
        end
        finish_run();
    end

endmodule